// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block is the SPI master side of a serial NOR flash controller. A host hands it one request at a time over a valid/ready handshake: a 3-bit operation code, a 24-bit address and a byte count. The block then builds every chip-select frame the flash needs and clocks it out in SPI mode 0 with 8-bit frames.

Each operation begins with a status poll. A read-status frame keeps clocking filler bytes until the busy bit of the returned status reads zero. Both erase types then issue a write-enable frame of their own before the erase frame. Reads use the fast-read command by default, with one filler byte between the address and the data. Each data byte is handed to the host on a valid/ready stream that honours backpressure. The identify operation captures three ID bytes and raises either a match flag or a no-device flag. The clear-protection operation writes zero into the flash status register.

The serial clock comes from a divider of the system clock that the host sets. A short idle gap, with chip select high, separates any two frames.

Top module: `spi_flash_seq`

## Requirements
- R1: `reqReady` is high only while the block is idle, and chip select is then high. After a request is accepted, `reqReady` stays low until the operation ends. The end is marked by a one-cycle `opDone`, during which `reqReady` is high again. The `reqOp` codes are: 0 read, 1 sector erase, 2 chip erase, 3 identify, 4 clear protection.
- R2: SPI mode 0. `sclk` is low whenever `csN` is high. Bytes are sent most significant bit first. `mosi` changes only while `sclk` is low. Each half period of `sclk` lasts `clkDiv`+1 system clocks.
- R3: Every operation starts with a frame that sends 0x05 and then 0xA5 filler bytes. The frame ends after the first returned status byte whose bit 0 (busy) is 0.
- R4: Sector erase and chip erase are each preceded by a frame that holds only the byte 0x06. The erase frame itself is 0x20 plus three address bytes for a sector erase, and the single byte 0xC7 for a chip erase.
- R5: For a sector erase, `reqAddr[11:0]` holds the sector index. The address sent is that index shifted left by 12, most significant byte first.
- R6: A read sends 0x0B, then `reqAddr` most significant byte first, then one 0xA5 filler byte. It then clocks `reqLen` bytes with 0xA5 on `mosi` and delivers each returned byte in order on `rdValid`/`rdData`. `rdData` holds steady while `rdReady` is low.
- R7: A read with `reqLen` = 0 sends only the five header bytes and produces no `rdValid`.
- R8: Identify sends 0x9F and three filler bytes, and places the three returned bytes, first byte highest, on `idBytes`. `idMatch` is set when they equal 0xBF, 0x25, 0x4A. Otherwise `noDevice` is set.
- R9: Clear protection sends a frame holding only 0x50, then a separate frame holding 0x01 followed by 0x00.
- R10: Between any two frames, `csN` stays high for at least 2 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clkDiv | input | 8 | Serial clock half period minus one, in system clocks |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Block idle, request accepted |
| reqOp | input | 3 | Operation code (see R1) |
| reqAddr | input | 24 | Byte address, or sector index for sector erase |
| reqLen | input | 16 | Number of data bytes to read |
| rdValid | output | 1 | Read byte valid |
| rdReady | input | 1 | Host takes the read byte |
| rdData | output | 8 | Read byte |
| opDone | output | 1 | One-cycle pulse at the end of an operation |
| idBytes | output | 24 | Last captured ID bytes |
| idMatch | output | 1 | Last identify matched the expected ID |
| noDevice | output | 1 | Last identify did not match |
| csN | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
A behavioural flash on the serial pins records every frame and answers status, ID and read data. The busy count it reports is varied: zero busy bytes checks that a single status byte ends the poll, and several busy bytes check that the poll frame grows by exactly that count. Reads are run at two divider settings, with and without host stalls, and with length zero. These runs separate a correct byte order and correct backpressure from off-by-one header or data counts. Identify is run with a good ID and with a wrong capacity byte, which shows whether the comparison covers all three bytes.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  typedef enum logic [2:0] {OP_READ, OP_SERASE, OP_CERASE, OP_IDENT, OP_UNPROT} op_e;
  typedef enum logic [2:0] {FR_POLL, FR_WREN, FR_MAIN, FR_EWSR, FR_WRSR} frame_e;
  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_XFER, ST_DRAIN, ST_GAP} state_e;

  typedef struct packed {
    logic       start;
    logic [7:0] tx;
  } sfl_cmd_t;

  typedef struct packed {
    logic       done;
    logic [7:0] rx;
  } sfl_rsp_t;

  localparam logic [7:0] OPC_READ   = 8'h03;
  localparam logic [7:0] OPC_FREAD  = 8'h0B;
  localparam logic [7:0] OPC_SERASE = 8'h20;
  localparam logic [7:0] OPC_CERASE = 8'hC7;
  localparam logic [7:0] OPC_RDSR   = 8'h05;
  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_EWSR   = 8'h50;
  localparam logic [7:0] OPC_WRSR   = 8'h01;
  localparam logic [7:0] OPC_JEDEC  = 8'h9F;
  localparam logic [7:0] FILL       = 8'hA5;
  localparam logic [23:0] ID_EXPECT = 24'hBF254A;
endpackage

// File: rtl/sfl_datapath.sv
module sfl_datapath
  import sfl_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] clkDiv,
  input  sfl_cmd_t         cmd,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output sfl_rsp_t         rsp
);
  logic [7:0]       shOut, shIn;
  logic [2:0]       bitCnt;
  logic [DIV_W-1:0] divCnt;
  logic             busyQ, sclkQ, doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shOut <= '0; shIn <= '0; bitCnt <= '0; divCnt <= '0;
      busyQ <= 1'b0; sclkQ <= 1'b0; doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (cmd.start && !busyQ) begin
        shOut  <= cmd.tx;
        busyQ  <= 1'b1;
        bitCnt <= '0;
        divCnt <= '0;
        sclkQ  <= 1'b0;
      end else if (busyQ) begin
        if (divCnt == clkDiv) begin
          divCnt <= '0;
          if (!sclkQ) begin
            sclkQ <= 1'b1;
            shIn  <= {shIn[6:0], miso};
          end else begin
            sclkQ  <= 1'b0;
            shOut  <= {shOut[6:0], 1'b0};
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              busyQ <= 1'b0;
              doneQ <= 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign sclk     = sclkQ;
  assign mosi     = shOut[7];
  assign rsp.done = doneQ;
  assign rsp.rx   = shIn;

  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sclkQ |-> $stable(mosi)); // R2
endmodule

// File: rtl/sfl_ctrl.sv
module sfl_ctrl
  import sfl_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int GAP_CLKS  = 2,
  parameter bit FAST_READ = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [2:0]       reqOp,
  input  logic [23:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  output logic             rdValid,
  input  logic             rdReady,
  output logic [7:0]       rdData,
  output logic             opDone,
  output logic [23:0]      idBytes,
  output logic             idMatch,
  output logic             noDevice,
  output logic             csN,
  output sfl_cmd_t         cmd,
  input  sfl_rsp_t         rsp
);
  localparam int IDX_W = LEN_W + 1;
  localparam int HDR   = FAST_READ ? 5 : 4;
  localparam int GAP_W = $clog2(GAP_CLKS) + 1;
  localparam logic [7:0] RD_OPC = FAST_READ ? OPC_FREAD : OPC_READ;

  state_e           state;
  frame_e           frame;
  op_e              opQ;
  logic [23:0]      addrQ, effAddr;
  logic [LEN_W-1:0] lenQ;
  logic [IDX_W-1:0] idx;
  logic [GAP_W-1:0] gapCnt;
  logic             pollClear, endFrame, csQ, rdValidQ, doneQ;
  logic [7:0]       txNext, hdrByte, rdDataQ;
  logic [23:0]      idReg;

  assign effAddr = (opQ == OP_SERASE) ? {addrQ[11:0], 12'h000} : addrQ;

  always_comb begin
    case (idx)
      IDX_W'(1): hdrByte = effAddr[23:16];
      IDX_W'(2): hdrByte = effAddr[15:8];
      IDX_W'(3): hdrByte = effAddr[7:0];
      default:   hdrByte = FILL;
    endcase
    txNext   = FILL;
    endFrame = 1'b0;
    case (frame)
      FR_POLL: begin txNext = (idx == '0) ? OPC_RDSR : FILL; endFrame = pollClear; end
      FR_WREN: begin txNext = OPC_WREN; endFrame = (idx != '0); end
      FR_EWSR: begin txNext = OPC_EWSR; endFrame = (idx != '0); end
      FR_WRSR: begin txNext = (idx == '0) ? OPC_WRSR : 8'h00; endFrame = (idx >= IDX_W'(2)); end
      FR_MAIN: begin
        case (opQ)
          OP_READ:   begin txNext = (idx == '0) ? RD_OPC : hdrByte;
                           endFrame = (idx == IDX_W'(HDR) + IDX_W'(lenQ)); end
          OP_SERASE: begin txNext = (idx == '0) ? OPC_SERASE : hdrByte;
                           endFrame = (idx == IDX_W'(4)); end
          OP_CERASE: begin txNext = OPC_CERASE; endFrame = (idx != '0); end
          OP_IDENT:  begin txNext = (idx == '0) ? OPC_JEDEC : FILL;
                           endFrame = (idx == IDX_W'(4)); end
          default:   endFrame = 1'b1;
        endcase
      end
      default: endFrame = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; frame <= FR_POLL; opQ <= OP_READ;
      addrQ <= '0; lenQ <= '0; idx <= '0; gapCnt <= '0;
      pollClear <= 1'b0; csQ <= 1'b1; rdValidQ <= 1'b0; doneQ <= 1'b0;
      rdDataQ <= '0; idReg <= '0; idBytes <= '0; idMatch <= 1'b0; noDevice <= 1'b0;
      cmd <= '0;
    end else begin
      cmd.start <= 1'b0;
      doneQ     <= 1'b0;
      case (state)
        ST_IDLE: if (reqValid) begin
          opQ <= op_e'(reqOp); addrQ <= reqAddr; lenQ <= reqLen;
          frame <= FR_POLL; idx <= '0; pollClear <= 1'b0;
          state <= ST_LOAD;
        end
        ST_LOAD: if (endFrame) begin
          csQ <= 1'b1; gapCnt <= '0; state <= ST_GAP;
          if (frame == FR_MAIN && opQ == OP_IDENT) begin
            idBytes  <= idReg;
            idMatch  <= (idReg == ID_EXPECT);
            noDevice <= (idReg != ID_EXPECT);
          end
        end else begin
          csQ <= 1'b0; cmd.start <= 1'b1; cmd.tx <= txNext; state <= ST_XFER;
        end
        ST_XFER: if (rsp.done) begin
          state <= ST_LOAD;
          idx   <= (frame == FR_POLL) ? IDX_W'(1) : idx + 1'b1;
          if (frame == FR_POLL && idx != '0 && !rsp.rx[0]) pollClear <= 1'b1;
          if (frame == FR_MAIN && opQ == OP_IDENT && idx != '0) idReg <= {idReg[15:0], rsp.rx};
          if (frame == FR_MAIN && opQ == OP_READ && idx >= IDX_W'(HDR)) begin
            rdDataQ <= rsp.rx; rdValidQ <= 1'b1; state <= ST_DRAIN;
          end
        end
        ST_DRAIN: if (rdReady) begin
          rdValidQ <= 1'b0; state <= ST_LOAD;
        end
        ST_GAP: begin
          gapCnt <= gapCnt + 1'b1;
          if (gapCnt == GAP_W'(GAP_CLKS - 1)) begin
            idx <= '0; pollClear <= 1'b0; state <= ST_LOAD;
            case (frame)
              FR_POLL: frame <= (opQ == OP_SERASE || opQ == OP_CERASE) ? FR_WREN :
                                (opQ == OP_UNPROT) ? FR_EWSR : FR_MAIN;
              FR_WREN: frame <= FR_MAIN;
              FR_EWSR: frame <= FR_WRSR;
              default: begin state <= ST_IDLE; doneQ <= 1'b1; end
            endcase
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign csN      = csQ;
  assign rdValid  = rdValidQ;
  assign rdData   = rdDataQ;
  assign opDone   = doneQ;

  AST_ACCEPT_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R1
  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> csN); // R1
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> reqReady); // R1
  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> (rdValid && $stable(rdData))); // R6
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> csN); // R10
endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
  import sfl_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int LEN_W     = 16,
  parameter int GAP_CLKS  = 2,
  parameter bit FAST_READ = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [2:0]       reqOp,
  input  logic [23:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  output logic             rdValid,
  input  logic             rdReady,
  output logic [7:0]       rdData,
  output logic             opDone,
  output logic [23:0]      idBytes,
  output logic             idMatch,
  output logic             noDevice,
  output logic             csN,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  sfl_cmd_t cmd;
  sfl_rsp_t rsp;

  sfl_ctrl #(.LEN_W(LEN_W), .GAP_CLKS(GAP_CLKS), .FAST_READ(FAST_READ)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqLen(reqLen),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData), .opDone(opDone),
    .idBytes(idBytes), .idMatch(idMatch), .noDevice(noDevice),
    .csN(csN), .cmd(cmd), .rsp(rsp)
  );

  sfl_datapath #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .clkDiv(clkDiv), .cmd(cmd), .miso(miso),
    .sclk(sclk), .mosi(mosi), .rsp(rsp)
  );

  AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk); // R2
endmodule

// File: tb/tb_spi_flash_seq.sv
module tb_spi_flash_seq;
  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0] clkDiv = 8'd1;
  logic reqValid = 1'b0, rdReady = 1'b0;
  logic [2:0] reqOp = '0;
  logic [23:0] reqAddr = '0;
  logic [15:0] reqLen = '0;
  logic reqReady, rdValid, opDone, idMatch, noDevice, csN, sclk, mosi, miso;
  logic [7:0] rdData;
  logic [23:0] idBytes;

  always #5 clk = ~clk;

  spi_flash_seq dut (
    .clk(clk), .rstN(rstN), .clkDiv(clkDiv), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqLen(reqLen), .rdValid(rdValid),
    .rdReady(rdReady), .rdData(rdData), .opDone(opDone), .idBytes(idBytes),
    .idMatch(idMatch), .noDevice(noDevice), .csN(csN), .sclk(sclk), .mosi(mosi),
    .miso(miso)
  );

  // Behavioural flash: records frames, answers status, ID and read data.
  logic [7:0] frames [0:63][0:15];
  int frameLen [0:63];
  int fCount = 0, statusServed = 0, busyUntil = 0;
  bit idBad = 1'b0;
  int bitCnt = 0, byteNum = 0;
  logic [7:0] inSh = '0, outSh = '0, nextOut = '0, opc = '0;
  logic [23:0] mAddr = '0;
  logic prevCs = 1'b1, prevSclk = 1'b0;

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(csN or sclk) begin
    if (csN !== prevCs) begin
      if (!csN) begin bitCnt = 0; byteNum = 0; outSh = '0; end
      else if (byteNum > 0 && fCount < 64) begin frameLen[fCount] = byteNum; fCount++; end
    end
    if (sclk !== prevSclk && !csN) begin
      if (sclk) begin
        inSh = {inSh[6:0], mosi};
        bitCnt++;
        if (bitCnt == 8) begin
          bitCnt = 0;
          if (byteNum < 16 && fCount < 64) frames[fCount][byteNum] = inSh;
          if (byteNum == 0) opc = inSh;
          if (byteNum >= 1 && byteNum <= 3) mAddr = {mAddr[15:0], inSh};
          nextOut = 8'h00;
          if (opc == 8'h05) begin
            nextOut = {7'b0, statusServed < busyUntil};
            statusServed++;
          end else if (opc == 8'h9F) begin
            case (byteNum + 1)
              1: nextOut = 8'hBF;
              2: nextOut = 8'h25;
              3: nextOut = idBad ? 8'h4B : 8'h4A;
              default: nextOut = 8'h00;
            endcase
          end else if (opc == 8'h0B && byteNum + 1 >= 5) begin
            nextOut = pat(mAddr + 24'(byteNum - 4));
          end
          byteNum++;
        end
      end else begin
        if (bitCnt == 0) outSh = nextOut;
        else outSh = {outSh[6:0], 1'b0};
      end
    end
    prevCs = csN;
    prevSclk = sclk;
  end
  assign miso = outSh[7];

  // Pin monitor: shortest chip-select gap and last sclk high length.
  int csHigh = 0, minGap = 1000000, sHigh = 0, lastHigh = 0;
  always @(posedge clk) begin
    if (csN) csHigh++;
    else begin
      if (csHigh > 0 && csHigh < minGap) minGap = csHigh;
      csHigh = 0;
    end
    if (sclk) sHigh++;
    else begin
      if (sHigh > 0) lastHigh = sHigh;
      sHigh = 0;
    end
  end

  int checks = 0, errors = 0, f0 = 0, gotN = 0;
  logic [7:0] got [0:63];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chkLen(input int fi, input int n, input string tag);
    chk(frameLen[f0 + fi] == n, tag, $sformatf("frame %0d length", fi), frameLen[f0 + fi], n);
  endtask

  task automatic chkB(input int fi, input int bi, input logic [7:0] e, input string tag);
    chk(frames[f0 + fi][bi] == e, tag, $sformatf("frame %0d byte %0d", fi, bi),
        int'(frames[f0 + fi][bi]), int'(e));
  endtask

  task automatic runOp(input int op, input int addr, input int len, input bit stall);
    int n;
    f0 = fCount; gotN = 0;
    @(negedge clk);
    reqOp = 3'(op); reqAddr = 24'(addr); reqLen = 16'(len); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R1", "ready low after accept", reqReady, 0);
    n = 0;
    while (!opDone && n < 40000) begin
      rdReady = stall ? (n % 3 == 2) : 1'b1;
      if (rdValid && rdReady && gotN < 64) begin got[gotN] = rdData; gotN++; end
      @(negedge clk);
      n++;
    end
    rdReady = 1'b0;
    chk(opDone && reqReady, "R1", "done pulse with ready", {opDone, reqReady}, 3);
    @(negedge clk);
    chk(!opDone, "R1", "done lasts one cycle", opDone, 0);
  endtask

  task automatic chkPoll(input int busyN, input string tag);
    chkB(0, 0, 8'h05, tag);
    chkB(0, 1, 8'hA5, tag);
    chkLen(0, busyN + 2, tag);
  endtask

  task automatic testIdentGood;
    busyUntil = statusServed;
    runOp(3, 0, 0, 0);
    chk(fCount - f0 == 2, "R8", "frame count", fCount - f0, 2);
    chkPoll(0, "R3");
    chkB(1, 0, 8'h9F, "R8"); chkB(1, 3, 8'hA5, "R8"); chkLen(1, 4, "R8");
    chk(idBytes == 24'hBF254A, "R8", "id bytes", idBytes, 24'hBF254A);
    chk(idMatch && !noDevice, "R8", "match flags", {idMatch, noDevice}, 2);
  endtask

  task automatic testIdentBad;
    idBad = 1'b1; busyUntil = statusServed;
    runOp(3, 0, 0, 0);
    idBad = 1'b0;
    chk(!idMatch && noDevice, "R8", "no-device flags", {idMatch, noDevice}, 1);
    chk(idBytes == 24'hBF254B, "R8", "bad id bytes", idBytes, 24'hBF254B);
  endtask

  task automatic testRead(input int addr, input int len, input int busyN, input bit stall, input int div);
    clkDiv = 8'(div);
    busyUntil = statusServed + busyN;
    runOp(0, addr, len, stall);
    chkPoll(busyN, "R3");
    chkB(1, 0, 8'h0B, "R6");
    chkB(1, 1, 8'(addr >> 16), "R6"); chkB(1, 2, 8'(addr >> 8), "R6"); chkB(1, 3, 8'(addr), "R6");
    chkB(1, 4, 8'hA5, "R6");
    if (len > 0) chkB(1, 5, 8'hA5, "R6");
    chkLen(1, 5 + len, len == 0 ? "R7" : "R6");
    chk(gotN == len, len == 0 ? "R7" : "R6", "bytes delivered", gotN, len);
    for (int i = 0; i < len && i < gotN; i++)
      chk(got[i] == pat(24'(addr + i)), "R6", $sformatf("data %0d", i), got[i], pat(24'(addr + i)));
    if (len > 0) chk(lastHigh == div + 1, "R2", "sclk half period", lastHigh, div + 1);
    clkDiv = 8'd1;
  endtask

  task automatic testSectorErase;
    busyUntil = statusServed + 2;
    runOp(1, 24'hFFF123, 0, 0);
    chk(fCount - f0 == 3, "R4", "frame count", fCount - f0, 3);
    chkPoll(2, "R3");
    chkB(1, 0, 8'h06, "R4"); chkLen(1, 1, "R4");
    chkB(2, 0, 8'h20, "R4"); chkLen(2, 4, "R4");
    chkB(2, 1, 8'h12, "R5"); chkB(2, 2, 8'h30, "R5"); chkB(2, 3, 8'h00, "R5");
  endtask

  task automatic testChipErase;
    busyUntil = statusServed;
    runOp(2, 0, 0, 0);
    chk(fCount - f0 == 3, "R4", "frame count", fCount - f0, 3);
    chkB(1, 0, 8'h06, "R4"); chkLen(1, 1, "R4");
    chkB(2, 0, 8'hC7, "R4"); chkLen(2, 1, "R4");
  endtask

  task automatic testUnprotect;
    busyUntil = statusServed + 1;
    runOp(4, 0, 0, 0);
    chk(fCount - f0 == 3, "R9", "frame count", fCount - f0, 3);
    chkPoll(1, "R3");
    chkB(1, 0, 8'h50, "R9"); chkLen(1, 1, "R9");
    chkB(2, 0, 8'h01, "R9"); chkB(2, 1, 8'h00, "R9"); chkLen(2, 2, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN && !sclk && reqReady && !rdValid && !opDone, "R1", "reset state",
        {csN, sclk, reqReady, rdValid, opDone}, 5'b10100);
    chk(!idMatch && !noDevice, "R8", "reset id flags", {idMatch, noDevice}, 0);
    testIdentGood();
    testIdentBad();
    testRead(24'h012345, 4, 3, 0, 1);
    testRead(24'h00FFFE, 6, 0, 1, 3);
    testRead(24'h0A0B0C, 0, 1, 0, 0);
    testRead(24'h123456, 3, 0, 1, 0);
    testSectorErase();
    testChipErase();
    testUnprotect();
    chk(minGap >= 2, "R10", "shortest chip-select gap", minGap, 2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end
endmodule